// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit half of a DMA engine that feeds a MAC. Software builds a ring of four-word buffer descriptors in memory, hands each one to the engine by setting its ownership flag, and pulses a start strobe. The engine then walks the ring on its own. For each descriptor it does the following, in order:

- reads the status word and checks ownership;
- reads the buffer length and the buffer address;
- streams the buffer out one byte at a time on a valid/ready interface;
- writes the status word back with ownership removed;
- moves on to the next descriptor.

A frame may be spread over several consecutive buffers. Two status bits say whether a buffer is the whole frame, the first part, a middle part or the last part. The engine marks the final byte of a frame so the MAC knows where the frame ends.

The ring has no fixed size. A descriptor carrying the end-of-ring flag sends the engine back to the ring base address. When the engine finds a descriptor it does not own, it parks on that descriptor and waits. The next start strobe makes it re-read that same descriptor, so software only has to arm descriptors and pulse start again.

Top module: `txring_walker`

## Requirements
- R1: After reset the engine is idle. It makes no memory request and presents no byte until `start` is pulsed.
- R2: The first `start` after reset reads the status word (offset 0) of the descriptor at `ring_base`. A descriptor is four 32-bit words: status at offset 0, buffer length in bits 31:16 of the word at offset 4, buffer byte address at offset 8, and an unused word at offset 12.
- R3: A status word with bit 31 clear stops the engine after that read, with no further memory access. The next `start` re-reads the same descriptor address.
- R4: A status word with bit 31 set makes the engine read the length word and then the address word. It then reads the buffer as 32-bit words and sends the bytes most significant first. For a length that is not a multiple of 4, only the leading bytes of the last word are sent.
- R5: After the last byte of a buffer is accepted, the engine writes the status word back to offset 0. Bit 31 is cleared and every other bit keeps the value that was read.
- R6: After the write-back, the next descriptor address is the current address plus 16 when status bit 30 is clear. When bit 30 is set, the next address is `ring_base`.
- R7: Status bits 29:28 give the buffer's place in its frame: 11 whole frame, 10 first, 00 middle, 01 last. `tx_last` is high on the final byte of a buffer coded 11 or 01, and low on every other byte.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. No memory request is issued while a byte is pending.
- R9: A `start` pulse while the engine is walking the ring has no effect on the sequence of memory accesses or bytes.
- R10: A memory request stays asserted, with a stable address and direction, until `mem_ack` is seen.
- R11: An owned descriptor with length zero sends no bytes. It is still written back, and the engine then advances to the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | 32 | Byte address of the first descriptor in the ring |
| start | input | 1 | One-cycle start/restart strobe from the CPU |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (status write-back) |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Byte to the MAC |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | MAC accepts the byte this cycle |
| tx_last | output | 1 | Final byte of a frame |

## Verification
A wrong internal pointer shows up at the memory port on the very next status read, because that read goes to an address the reference model does not expect. A wrong length or remaining-byte count shows up at the byte port as an extra byte, a missing byte or a misplaced frame-end. This is caught at the first mismatching byte, or at the write-back, which then arrives early or late. A status register that was captured badly, or that drifted, is exposed at the write-back, whose data is compared bit for bit. A pending byte that changes during a stall is caught in the next cycle.

// File: rtl/txring_pkg.sv
// Shared definitions for the transmit descriptor ring walker.
// Assumes 32-bit descriptor words; bit positions below are the ones software uses.
package txring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT,
        ST_LEN,
        ST_BADDR,
        ST_DATA,
        ST_DRAIN,
        ST_WBACK
    } walk_state_t;

    localparam int OWN_BIT      = 31;
    localparam int RING_END_BIT = 30;
    localparam int FPOS_HI_BIT  = 29;
    localparam int FPOS_LO_BIT  = 28;

    localparam logic [1:0] FPOS_WHOLE = 2'b11;
    localparam logic [1:0] FPOS_FIRST = 2'b10;
    localparam logic [1:0] FPOS_MID   = 2'b00;
    localparam logic [1:0] FPOS_TAIL  = 2'b01;

    typedef struct packed {
        logic owned;
        logic ring_end;
        logic closes_frame;
    } desc_flags_t;

endpackage

// File: rtl/txring_desc_decode.sv
// Descriptor status decoder.
// Splits a captured status word into the flags the sequencer acts on and
// forms the write-back word with only the ownership bit cleared.
// Assumes DATA_W is at least 32 so the fixed flag positions exist.
module txring_desc_decode
    import txring_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] status_word,
    output desc_flags_t       flags,
    output logic [DATA_W-1:0] wback_word
);

    logic [1:0] fpos;

    // Decode the flags and the frame position code.
    always_comb begin
        fpos               = {status_word[FPOS_HI_BIT], status_word[FPOS_LO_BIT]};
        flags.owned        = status_word[OWN_BIT];
        flags.ring_end     = status_word[RING_END_BIT];
        flags.closes_frame = (fpos == FPOS_WHOLE) || (fpos == FPOS_TAIL);
    end

    // Clear only the ownership bit for the write-back.
    always_comb begin
        wback_word          = status_word;
        wback_word[OWN_BIT] = 1'b0;
    end

endmodule

// File: rtl/txring_byte_ser.sv
// Word-to-byte serializer.
// Holds one fetched word and presents its bytes most significant first on a
// valid/ready stream. Assumes load is only pulsed while empty is high.
module txring_byte_ser #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int CW    = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    input  logic [CW-1:0]     nbytes,
    input  logic              closes,
    output logic              empty,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last
);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     left;
    logic              closes_q;

    // Load a word, or shift out one byte per accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            left     <= '0;
            closes_q <= 1'b0;
        end else if (load) begin
            shreg    <= word;
            left     <= nbytes;
            closes_q <= closes;
        end else if ((left != '0) && tx_ready) begin
            shreg <= shreg << 8;
            left  <= left - CW'(1);
        end
    end

    assign empty    = (left == '0);
    assign tx_valid = (left != '0);
    assign tx_data  = shreg[DATA_W-1 -: 8];
    assign tx_last  = closes_q && (left == CW'(1));

endmodule

// File: rtl/txring_walker.sv
// Transmit descriptor ring walker (top).
// Sequences status read, ownership check, length and address fetch, buffer
// streaming, status write-back and ring advance. Assumes word-aligned ring
// base and buffer addresses and a memory that holds mem_req until mem_ack.
module txring_walker
    import txring_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 16,
    parameter int DESC_STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last
);

    localparam int NB = DATA_W / 8;
    localparam int CW = $clog2(NB + 1);

    walk_state_t       state;
    logic [ADDR_W-1:0] desc_ptr;
    logic              ptr_loaded;
    logic [DATA_W-1:0] status_q;
    logic [LEN_W-1:0]  remain;
    logic [ADDR_W-1:0] buf_ptr;

    desc_flags_t       flags_q;
    logic [DATA_W-1:0] wback_word;
    logic [CW-1:0]     take;
    logic              ser_load;
    logic              ser_closes;
    logic              ser_empty;

    txring_desc_decode #(.DATA_W(DATA_W)) u_decode (
        .status_word (status_q),
        .flags       (flags_q),
        .wback_word  (wback_word)
    );

    // Bytes taken from the word being fetched: a full word or the tail.
    always_comb begin
        if (remain >= LEN_W'(NB)) take = CW'(NB);
        else                      take = CW'(remain);
    end

    assign ser_load   = (state == ST_DATA) && mem_ack;
    assign ser_closes = flags_q.closes_frame && (remain == LEN_W'(take));

    txring_byte_ser #(.DATA_W(DATA_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_load),
        .word     (mem_rdata),
        .nbytes   (take),
        .closes   (ser_closes),
        .empty    (ser_empty),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_last  (tx_last)
    );

    // Drive the memory request from the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_wdata = wback_word;
        unique case (state)
            ST_STAT:  mem_addr = desc_ptr;
            ST_LEN:   mem_addr = desc_ptr + ADDR_W'(NB);
            ST_BADDR: mem_addr = desc_ptr + ADDR_W'(2 * NB);
            ST_DATA:  mem_addr = buf_ptr;
            ST_WBACK: begin
                mem_addr = desc_ptr;
                mem_we   = 1'b1;
            end
            default: begin
                mem_addr = desc_ptr;
                mem_req  = 1'b0;
            end
        endcase
    end

    // Descriptor sequencer: one state per memory access plus drain and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            desc_ptr   <= '0;
            ptr_loaded <= 1'b0;
            status_q   <= '0;
            remain     <= '0;
            buf_ptr    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_STAT;
                        if (!ptr_loaded) begin
                            desc_ptr   <= ring_base;
                            ptr_loaded <= 1'b1;
                        end
                    end
                end
                ST_STAT: begin
                    if (mem_ack) begin
                        status_q <= mem_rdata;
                        state    <= mem_rdata[OWN_BIT] ? ST_LEN : ST_IDLE;
                    end
                end
                ST_LEN: begin
                    if (mem_ack) begin
                        remain <= mem_rdata[DATA_W-1 -: LEN_W];
                        state  <= ST_BADDR;
                    end
                end
                ST_BADDR: begin
                    if (mem_ack) begin
                        buf_ptr <= mem_rdata[ADDR_W-1:0];
                        state   <= (remain == '0) ? ST_WBACK : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (mem_ack) begin
                        buf_ptr <= buf_ptr + ADDR_W'(NB);
                        remain  <= remain - LEN_W'(take);
                        state   <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (ser_empty) state <= (remain == '0) ? ST_WBACK : ST_DATA;
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        desc_ptr <= flags_q.ring_end ? ring_base
                                                     : desc_ptr + ADDR_W'(DESC_STRIDE);
                        state    <= ST_STAT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txring_walker_chk.sv
// Protocol checker for the ring walker, bound to every instance of the top.
// Observes only the top's ports.
module txring_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last
);

    // R8: a stalled byte holds its data and frame-end flag.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R8: no memory traffic while a byte is pending.
    p_quiet_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);

    // R10: a request is held steady until acknowledged.
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5: every write-back releases ownership.
    p_wback_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[DATA_W-1]);

    // R7: a frame end is only flagged on a presented byte.
    p_last_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

endmodule

bind txring_walker txring_walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last)
);

// File: tb/tb_txring_walker.sv
// Bench: behavioural memory, behavioural ring model producing expected
// memory operations and bytes, compared against the ports every clock.
module tb_txring_walker;

    localparam logic [31:0] BASE = 32'h0000_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tx_ready = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;

    logic [31:0] mem [0:1023];
    logic [8:0]  exp_bytes [$];
    logic [64:0] exp_ops [$];
    logic [31:0] model_ptr = BASE;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    txring_walker dut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
    );

    function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endfunction

    // Memory: acknowledges one cycle after a request is seen.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[11:2]];
                if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            end
        end
    end

    // Per-clock comparison, sampled between the input drive and the next edge.
    logic        stalled_prev = 1'b0;
    logic [8:0]  prev_byte = '0;
    logic        req_prev = 1'b0;
    logic [32:0] prev_req = '0;
    always @(posedge clk) begin
        #6;
        cyc++;
        if (rst_n) begin
            if (stalled_prev)
                chk(tx_valid && {tx_last, tx_data} == prev_byte, "R8 stalled byte changed",
                    {tx_valid, tx_last, tx_data}, {1'b1, prev_byte});
            if (tx_valid) begin
                if (exp_bytes.size() == 0) chk(0, "R4 unexpected byte", tx_data, 0);
                else begin
                    chk(tx_data == exp_bytes[0][7:0], "R4 byte value", tx_data, exp_bytes[0][7:0]);
                    chk(tx_last == exp_bytes[0][8], "R7 frame end flag", tx_last, exp_bytes[0][8]);
                    if (tx_ready) void'(exp_bytes.pop_front());
                end
            end
            stalled_prev = tx_valid && !tx_ready;
            prev_byte    = {tx_last, tx_data};
            if (req_prev)
                chk(mem_req && {mem_we, mem_addr} == prev_req, "R10 request dropped or moved",
                    {mem_req, mem_we, mem_addr}, {1'b1, prev_req});
            if (mem_req && mem_ack) begin
                if (exp_ops.size() == 0) chk(0, "R3 unexpected memory access", mem_addr, 0);
                else if (exp_ops[0][64]) begin
                    chk(mem_we && mem_addr == exp_ops[0][63:32] && mem_wdata == exp_ops[0][31:0],
                        "R5 write-back", {mem_addr, mem_wdata}, exp_ops[0][63:0]);
                    void'(exp_ops.pop_front());
                end else begin
                    chk(!mem_we && mem_addr == exp_ops[0][63:32], "R6 read address order",
                        {31'h0, mem_we, mem_addr}, {32'h0, exp_ops[0][63:32]});
                    void'(exp_ops.pop_front());
                end
            end
            req_prev = mem_req && !mem_ack;
            prev_req = {mem_we, mem_addr};
        end
    end

    // Behavioural ring model: expected operations and bytes from model_ptr.
    task automatic model_run();
        logic [31:0] sh [0:1023];
        logic [31:0] p, st, ba, w, wb;
        int len;
        for (int i = 0; i < 1024; i++) sh[i] = mem[i];
        p = model_ptr;
        for (int n = 0; n < 16; n++) begin
            st = sh[p[11:2]];
            exp_ops.push_back({1'b0, p, 32'h0});
            if (!st[31]) break;
            exp_ops.push_back({1'b0, p + 32'd4, 32'h0});
            len = int'(sh[(p + 32'd4) >> 2][31:16]);
            exp_ops.push_back({1'b0, p + 32'd8, 32'h0});
            ba = sh[(p + 32'd8) >> 2];
            for (int i = 0; i < len; i++) begin
                if (i % 4 == 0) exp_ops.push_back({1'b0, ba + 32'(i), 32'h0});
                w = sh[(ba + 32'(i)) >> 2];
                exp_bytes.push_back({(i == len - 1) && st[28], w[31 - 8 * (i % 4) -: 8]});
            end
            wb = st & 32'h7FFF_FFFF;
            exp_ops.push_back({1'b1, p, wb});
            sh[p[11:2]] = wb;
            p = st[30] ? BASE : p + 32'd16;
        end
        model_ptr = p;
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [31:0] st,
                            input logic [15:0] len, input logic [31:0] ba);
        mem[a[11:2]]       = st;
        mem[a[11:2] + 1]   = {len, 16'h0};
        mem[a[11:2] + 2]   = ba;
        mem[a[11:2] + 3]   = 32'hDEAD_0000;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_drained(input string tag);
        for (int i = 0; i < 5000 && (exp_bytes.size() != 0 || exp_ops.size() != 0); i++)
            @(negedge clk);
        chk(exp_bytes.size() == 0 && exp_ops.size() == 0, tag, exp_bytes.size(), 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(!mem_req && !tx_valid, "R3 engine not halted", mem_req, 0);
        end
    endtask

    // Ready pattern with periodic stalls.
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = !((cyc % 5) == 2 || (cyc % 7) == 0);
        end
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++)
            mem[i] = {8'(i), 8'(i + 1) ^ 8'h5A, ~8'(i), 8'(i * 3)};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!mem_req && !tx_valid, "R1 idle after reset", {mem_req, tx_valid}, 0);
        end

        // R2, R4, R5, R6, R7, R9: three-buffer frame, then unowned descriptor
        set_desc(32'h40, 32'h8000_0000 | (32'h2 << 28) | 32'h123, 16'd5, 32'h200);
        set_desc(32'h50, 32'h8000_0000 | (32'h0 << 28) | 32'hABC, 16'd4, 32'h240);
        set_desc(32'h60, 32'h8000_0000 | (32'h1 << 28) | 32'h0F0, 16'd3, 32'h280);
        set_desc(32'h70, 32'h0000_0005, 16'd2, 32'h2C0);
        model_run();
        pulse_start();
        repeat (12) @(negedge clk);
        pulse_start(); // R9: ignored while walking
        wait_drained("R2 first pass incomplete");

        // R3, R6, R7: restart resumes at the halted descriptor, which wraps the ring
        set_desc(32'h70, 32'hC000_0000 | (32'h3 << 28) | 32'h011, 16'd7, 32'h2C0);
        model_run();
        pulse_start();
        wait_drained("R3 resume pass incomplete");

        // R11: zero-length owned descriptor at the ring base
        set_desc(32'h40, 32'h8000_0000 | (32'h3 << 28) | 32'h077, 16'd0, 32'h300);
        model_run();
        pulse_start();
        wait_drained("R11 zero-length pass incomplete");

        // R4, R7: whole frames of 8 and 6 bytes back to back
        set_desc(32'h50, 32'h8000_0000 | (32'h3 << 28), 16'd8, 32'h300);
        set_desc(32'h60, 32'hC000_0000 | (32'h3 << 28) | 32'h3, 16'd6, 32'h320);
        model_run();
        pulse_start();
        wait_drained("R4 back-to-back frames incomplete");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule